// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block moves a processor into an exception or interrupt handler and later brings it back out. The core asserts `enter_req` with the exception index, a flag that marks a hardware interrupt, the pending interrupt level, and its current PC, status register (SR) and stack pointer (SP). The sequencer builds a two-longword frame and pushes it through a simple 32-bit request/acknowledge memory port. It then reads the handler address from the vector table and presents the new PC, SR and SP for one cycle on `done`.

For the way back, the core asserts `ret_req` with SP pointing at a frame. The sequencer reads the frame word and the saved PC, and then presents the restored PC, SR and SP. The frame word keeps the two low bits of the stack pointer as it was before alignment. Because of this, a return after an entry from an odd stack pointer gives back exactly the original value.

The state machine has seven named states. The entry path is IDLE → PUSH_PC → PUSH_FMT → FETCH_VEC → DONE → IDLE. The return path is IDLE → POP_FMT → POP_PC → DONE → IDLE. A memory state moves on only in the cycle where `mem_ack` is high. DONE always returns to IDLE after one cycle. IDLE goes to PUSH_PC when an entry is accepted. If no entry is accepted and `ret_req` is high, IDLE goes to POP_FMT instead.

Top module: `exc_frame_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mem_req` are low until a request is accepted.
- R2: The pushed frame word is laid out as follows. Bits 31:30 hold 2'b01. Bits 29:28 hold the incoming SP bits 1:0. Bits 27:26 are zero. Bits 25:18 hold the exception index, so bits 25:16 carry the index times 4. Bits 17:16 are zero. Bits 15:0 hold the incoming SR.
- R3: The incoming SP is first rounded down to a multiple of 4 (call this A). The return address is then written to A-4 and the frame word to A-8, in that order. The committed SP is A-8.
- R4: A software exception whose index is in 32..47 pushes PC+2 as the return address. Every other case pushes PC, and this includes any hardware interrupt.
- R5: On entry, the committed SR is the incoming SR with bit 13 (supervisor) set. For a hardware interrupt, bits 10:8 (mask) are also loaded with the pending level, and bit 12 (master) is cleared.
- R6: After pushing, the handler address is read from the vector base plus the index times 4, and the committed PC is the value read.
- R7: A return reads the frame word at SP and then the PC at SP+4. It commits that PC, SR equal to frame bits 15:0, and SP equal to (SP OR frame bits 29:28) + 8.
- R8: A hardware-interrupt entry is taken only when the pending level is strictly greater than SR bits 10:8. Otherwise the request is ignored: no memory access is made and `busy` stays low.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from the first cycle of an access until the cycle in which `mem_ack` is seen. Written addresses are longword aligned.
- R10: `busy` rises the cycle after a request is accepted and stays high through the single `done` cycle. `done` lasts exactly one cycle. Any `enter_req` or `ret_req` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enter_req | input | 1 | Start exception or interrupt entry |
| ret_req | input | 1 | Start return from handler |
| is_hw | input | 1 | Entry is a hardware interrupt |
| exc_idx | input | 8 | Exception index |
| irq_lvl | input | 3 | Pending interrupt level |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status register |
| cur_sp | input | 32 | Stack pointer for the frame |
| vbr | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle commit strobe |
| new_pc | output | 32 | Committed PC |
| new_sr | output | 16 | Committed SR |
| new_sp | output | 32 | Committed SP |

## Verification
Software entries are driven with indices just inside and just outside the trap window (31, 32, 47, 48). This separates the PC+2 return address from the plain one. A hardware interrupt whose index lies inside that window confirms that hardware entries never add 2. Hardware interrupts with the level above, equal to and below the mask check the strict comparison and the mask, master and supervisor rewrite. An odd starting SP followed by a return through the frame just written shows that the misalignment bits restore SP exactly. Memory latencies of zero to two wait cycles, and requests issued mid-sequence, test the handshake hold and the rule that requests are ignored while busy.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
    localparam int XLEN  = 32;
    localparam int SR_W  = 16;
    localparam int IDX_W = 8;
    localparam int LVL_W = 3;

    localparam logic [1:0] FRAME_TAG = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_FMT,
        ST_FETCH_VEC,
        ST_DONE,
        ST_POP_FMT,
        ST_POP_PC
    } seq_state_t;

    typedef struct packed {
        logic [1:0]       tag;
        logic [1:0]       mis;
        logic [1:0]       pad;
        logic [IDX_W-1:0] idx;
        logic [1:0]       zero;
        logic [SR_W-1:0]  sr;
    } frame_word_t;
endpackage

// File: rtl/exc_frame_build.sv
module exc_frame_build
    import exc_frame_pkg::*;
#(
    parameter int TRAP_BASE = 32,
    parameter int TRAP_NUM  = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             is_hw,
    input  logic [XLEN-1:0]  pc,
    input  logic [SR_W-1:0]  sr,
    input  logic [XLEN-1:0]  sp,
    output frame_word_t      frame,
    output logic [XLEN-1:0]  ret_addr,
    output logic [XLEN-1:0]  sp_aligned,
    output logic [XLEN-1:0]  vec_off
);
    localparam logic [XLEN-1:0] TRAP_LO = XLEN'(TRAP_BASE);
    localparam logic [XLEN-1:0] TRAP_HI = XLEN'(TRAP_BASE + TRAP_NUM);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(2);

    logic [XLEN-1:0] idx_wide;
    logic            is_trap;

    assign idx_wide = {{(XLEN-IDX_W){1'b0}}, idx};

    generate
        if (TRAP_NUM > 0) begin : g_trap
            assign is_trap = !is_hw && (idx_wide >= TRAP_LO) && (idx_wide < TRAP_HI);
        end else begin : g_no_trap
            assign is_trap = 1'b0;
        end
    endgenerate

    assign ret_addr   = is_trap ? (pc + PC_STEP) : pc;
    assign sp_aligned = {sp[XLEN-1:2], 2'b00};
    assign vec_off    = {{(XLEN-IDX_W-2){1'b0}}, idx, 2'b00};

    always_comb begin
        frame      = '0;
        frame.tag  = FRAME_TAG;
        frame.mis  = sp[1:0];
        frame.idx  = idx;
        frame.sr   = sr;
    end
endmodule

// File: rtl/exc_sr_entry.sv
module exc_sr_entry
    import exc_frame_pkg::*;
#(
    parameter int S_BIT = 13,
    parameter int M_BIT = 12,
    parameter int I_LSB = 8
) (
    input  logic [SR_W-1:0]  sr_in,
    input  logic             is_hw,
    input  logic [LVL_W-1:0] lvl,
    output logic [SR_W-1:0]  sr_out
);
    always_comb begin
        sr_out        = sr_in;
        sr_out[S_BIT] = 1'b1;
        if (is_hw) begin
            sr_out[I_LSB +: LVL_W] = lvl;
            sr_out[M_BIT]          = 1'b0;
        end
    end
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
    import exc_frame_pkg::*;
(
    input  logic [LVL_W-1:0] mask,
    input  logic [LVL_W-1:0] lvl,
    output logic             accept
);
    assign accept = lvl > mask;
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int TRAP_BASE = 32,
    parameter int TRAP_NUM  = 16,
    parameter int SR_S_BIT  = 13,
    parameter int SR_M_BIT  = 12,
    parameter int SR_I_LSB  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_req,
    input  logic             ret_req,
    input  logic             is_hw,
    input  logic [IDX_W-1:0] exc_idx,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [SR_W-1:0]  cur_sr,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  vbr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  new_pc,
    output logic [SR_W-1:0]  new_sr,
    output logic [XLEN-1:0]  new_sp
);
    localparam logic [XLEN-1:0] STEP4 = XLEN'(4);
    localparam logic [XLEN-1:0] STEP8 = XLEN'(8);

    seq_state_t state, state_nx;

    logic             irq_ok;
    logic             entry_go;
    logic             ret_go;

    logic [IDX_W-1:0] idx_q;
    logic             hw_q;
    logic [LVL_W-1:0] lvl_q;
    logic [XLEN-1:0]  pc_q;
    logic [SR_W-1:0]  sr_q;
    logic [XLEN-1:0]  sp_q;
    logic [XLEN-1:0]  vbr_q;
    logic [1:0]       fmt_mis_q;
    logic [SR_W-1:0]  fmt_sr_q;

    frame_word_t      frame;
    logic [XLEN-1:0]  ret_addr;
    logic [XLEN-1:0]  sp_al;
    logic [XLEN-1:0]  vec_off;
    logic [SR_W-1:0]  entry_sr;

    exc_irq_gate u_gate (
        .mask   (cur_sr[SR_I_LSB +: LVL_W]),
        .lvl    (irq_lvl),
        .accept (irq_ok)
    );

    exc_frame_build #(
        .TRAP_BASE (TRAP_BASE),
        .TRAP_NUM  (TRAP_NUM)
    ) u_build (
        .idx        (idx_q),
        .is_hw      (hw_q),
        .pc         (pc_q),
        .sr         (sr_q),
        .sp         (sp_q),
        .frame      (frame),
        .ret_addr   (ret_addr),
        .sp_aligned (sp_al),
        .vec_off    (vec_off)
    );

    exc_sr_entry #(
        .S_BIT (SR_S_BIT),
        .M_BIT (SR_M_BIT),
        .I_LSB (SR_I_LSB)
    ) u_sr (
        .sr_in  (sr_q),
        .is_hw  (hw_q),
        .lvl    (lvl_q),
        .sr_out (entry_sr)
    );

    assign entry_go = enter_req && (!is_hw || irq_ok);
    assign ret_go   = ret_req && !entry_go;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (entry_go)    state_nx = ST_PUSH_PC;
                else if (ret_go) state_nx = ST_POP_FMT;
            end
            ST_PUSH_PC:   if (mem_ack) state_nx = ST_PUSH_FMT;
            ST_PUSH_FMT:  if (mem_ack) state_nx = ST_FETCH_VEC;
            ST_FETCH_VEC: if (mem_ack) state_nx = ST_DONE;
            ST_POP_FMT:   if (mem_ack) state_nx = ST_POP_PC;
            ST_POP_PC:    if (mem_ack) state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_al - STEP4;
                mem_wdata = ret_addr;
            end
            ST_PUSH_FMT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_al - STEP8;
                mem_wdata = frame;
            end
            ST_FETCH_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vbr_q + vec_off;
            end
            ST_POP_FMT: begin
                mem_req  = 1'b1;
                mem_addr = sp_q;
            end
            ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = sp_q + STEP4;
            end
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // Captured context and commit registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            hw_q      <= 1'b0;
            lvl_q     <= '0;
            pc_q      <= '0;
            sr_q      <= '0;
            sp_q      <= '0;
            vbr_q     <= '0;
            fmt_mis_q <= '0;
            fmt_sr_q  <= '0;
            new_pc    <= '0;
            new_sr    <= '0;
            new_sp    <= '0;
        end else begin
            if (state == ST_IDLE && (entry_go || ret_go)) begin
                idx_q <= exc_idx;
                hw_q  <= is_hw && entry_go;
                lvl_q <= irq_lvl;
                pc_q  <= cur_pc;
                sr_q  <= cur_sr;
                sp_q  <= cur_sp;
                vbr_q <= vbr;
            end
            if (state == ST_FETCH_VEC && mem_ack) begin
                new_pc <= mem_rdata;
                new_sr <= entry_sr;
                new_sp <= sp_al - STEP8;
            end
            if (state == ST_POP_FMT && mem_ack) begin
                fmt_mis_q <= mem_rdata[29:28];
                fmt_sr_q  <= mem_rdata[SR_W-1:0];
            end
            if (state == ST_POP_PC && mem_ack) begin
                new_pc <= mem_rdata;
                new_sr <= fmt_sr_q;
                new_sp <= (sp_q | {{(XLEN-2){1'b0}}, fmt_mis_q}) + STEP8;
            end
        end
    end

    // R9: access held steady until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: pushes go to longword addresses
    a_r9_write_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00));

    // R10: commit strobe lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no access outside a busy window
    a_r10_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || done) |-> busy);

    // R8: refused interrupt leaves the sequencer idle
    a_r8_refused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && enter_req && is_hw && !irq_ok && !ret_req) |=> !busy);

    // R5: supervisor bit set on every entry commit
    a_r5_supervisor_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_VEC && mem_ack) |=> new_sr[SR_S_BIT]);
endmodule

// File: tb/exc_frame_seq_tb.sv
module exc_frame_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_req = 1'b0;
    logic        ret_req = 1'b0;
    logic        is_hw = 1'b0;
    logic [7:0]  exc_idx = '0;
    logic [2:0]  irq_lvl = '0;
    logic [31:0] cur_pc = '0;
    logic [15:0] cur_sr = '0;
    logic [31:0] cur_sp = '0;
    logic [31:0] vbr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done;
    logic [31:0] new_pc, new_sp;
    logic [15:0] new_sr;

    always #5 clk = ~clk;

    exc_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .ret_req(ret_req),
        .is_hw(is_hw), .exc_idx(exc_idx), .irq_lvl(irq_lvl), .cur_pc(cur_pc),
        .cur_sr(cur_sr), .cur_sp(cur_sp), .vbr(vbr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .new_pc(new_pc), .new_sr(new_sr), .new_sp(new_sp)
    );

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 commit
        logic [31:0] addr;
        logic [31:0] data;
        logic [15:0] sr;
        logic [31:0] sp;
        string       req;
    } item_t;

    item_t       sb[$];
    logic [31:0] mem[logic [31:0]];
    int          lat = 0;
    int          checks = 0;
    int          errors = 0;

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] frame_of(input logic [7:0] idx, input logic [15:0] sr, input logic [31:0] sp);
        return 32'h4000_0000 | ({30'd0, sp[1:0]} << 28) | ({24'd0, idx} << 18) | {16'd0, sr};
    endfunction

    // Memory responder with configurable wait states
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                mem_ack <= 1'b0;
                cnt = 0;
            end else if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                if (cnt >= lat) begin
                    cnt = 0;
                    mem_ack <= 1'b1;
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : (32'hDEAD_0000 ^ mem_addr);
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Monitor: pop and compare as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ((mem_req && mem_ack) || done)) begin
                if (sb.size() == 0) begin
                    chk("R10", "unexpected activity", {30'd0, done, mem_req}, 32'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (done) begin
                        chk(it.req, "commit kind", 32'(it.kind), 32'd2);
                        chk(it.req, "new_pc", new_pc, it.data);
                        chk(it.req, "new_sr", {16'd0, new_sr}, {16'd0, it.sr});
                        chk(it.req, "new_sp", new_sp, it.sp);
                    end else begin
                        chk(it.req, "access kind", {31'd0, mem_we}, (it.kind == 0) ? 32'd1 : 32'd0);
                        chk(it.req, "address", mem_addr, it.addr);
                        if (it.kind == 0) chk(it.req, "write data", mem_wdata, it.data);
                    end
                end
            end
        end
    end

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] d,
                        input logic [15:0] s, input logic [31:0] p, input string r);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.sr = s; it.sp = p; it.req = r;
        sb.push_back(it);
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (sb.size() == 0) break;
        end
        chk("R10", "queue drained", 32'(sb.size()), 32'd0);
        @(negedge clk);
        chk("R10", "busy after commit", {31'd0, busy}, 32'd0);
    endtask

    task automatic do_entry(input logic [7:0] idx, input logic hw, input logic [2:0] lvl,
                            input logic [31:0] pc, input logic [15:0] sr, input logic [31:0] sp,
                            input logic [31:0] vb, input logic [31:0] handler, input string r);
        logic [31:0] al, ra;
        logic [15:0] nsr;
        al  = {sp[31:2], 2'b00};
        ra  = (!hw && idx >= 8'd32 && idx <= 8'd47) ? pc + 32'd2 : pc;
        nsr = sr | 16'h2000;
        if (hw) nsr = (nsr & ~16'h1700) | {5'd0, lvl, 8'd0};
        mem[vb + {22'd0, idx, 2'b00}] = handler;
        push(0, al - 32'd4, ra, '0, '0, r);
        push(0, al - 32'd8, frame_of(idx, sr, sp), '0, '0, r);
        push(1, vb + {22'd0, idx, 2'b00}, '0, '0, '0, r);
        push(2, '0, handler, nsr, al - 32'd8, r);
        @(negedge clk);
        exc_idx = idx; is_hw = hw; irq_lvl = lvl; cur_pc = pc; cur_sr = sr; cur_sp = sp; vbr = vb;
        enter_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
        chk("R10", "busy after start", {31'd0, busy}, 32'd1);
    endtask

    task automatic do_ret(input logic [31:0] sp, input logic preload, input logic [31:0] fmt,
                          input logic [31:0] pc, input logic [15:0] exp_sr, input logic [31:0] exp_sp,
                          input string r);
        if (preload) begin
            mem[sp] = fmt;
            mem[sp + 32'd4] = pc;
        end
        push(1, sp, '0, '0, '0, r);
        push(1, sp + 32'd4, '0, '0, '0, r);
        push(2, '0, pc, exp_sr, exp_sp, r);
        @(negedge clk);
        cur_sp = sp;
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk("R10", "busy after return start", {31'd0, busy}, 32'd1);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
        chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", {31'd0, done}, 32'd0);
        chk("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);

        // Plain software exception, aligned stack (R2 R3 R5 R6)
        do_entry(8'd5, 1'b0, 3'd0, 32'h0000_1000, 16'h0015, 32'h0000_8000, 32'h0, 32'h4000_0100, "R2/R3/R6");
        drain();

        // Trap window edges (R4)
        lat = 1;
        do_entry(8'd32, 1'b0, 3'd0, 32'h0000_2000, 16'h2704, 32'h0000_9000, 32'h0000_1000, 32'h1111_0000, "R4");
        drain();
        do_entry(8'd47, 1'b0, 3'd0, 32'h0000_2100, 16'h0000, 32'h0000_9000, 32'h0000_1000, 32'h1111_0004, "R4");
        drain();
        do_entry(8'd48, 1'b0, 3'd0, 32'h0000_2200, 16'h0000, 32'h0000_9000, 32'h0000_1000, 32'h1111_0008, "R4");
        drain();
        do_entry(8'd31, 1'b0, 3'd0, 32'h0000_2300, 16'h0000, 32'h0000_9000, 32'h0000_1000, 32'h1111_000C, "R4");
        drain();

        // Misaligned stack pointer (R2 R3)
        lat = 2;
        do_entry(8'd9, 1'b0, 3'd0, 32'h0000_3000, 16'h0101, 32'h0000_1003, 32'h0, 32'h2222_0000, "R3");
        drain();

        // Hardware interrupt accepted, mask/master rewrite (R5 R8)
        lat = 0;
        do_entry(8'h19, 1'b1, 3'd5, 32'h0000_4000, 16'h3200, 32'h0000_A000, 32'h0, 32'h3333_0000, "R5");
        drain();

        // Hardware interrupt inside trap window gets no +2 (R4)
        do_entry(8'd40, 1'b1, 3'd7, 32'h0000_4100, 16'h2600, 32'h0000_A000, 32'h0, 32'h3333_0004, "R4");
        drain();

        // Refused interrupts: equal and lower level (R8)
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            is_hw = 1'b1; exc_idx = 8'h1A; cur_sr = 16'h2300; irq_lvl = (k == 0) ? 3'd3 : 3'd1;
            enter_req = 1'b1;
            @(negedge clk);
            enter_req = 1'b0;
            for (int c = 0; c < 4; c++) begin
                chk("R8", "refused busy", {31'd0, busy}, 32'd0);
                chk("R8", "refused mem_req", {31'd0, mem_req}, 32'd0);
                @(negedge clk);
            end
        end
        is_hw = 1'b0;

        // Return from a prepared frame (R7)
        lat = 1;
        do_ret(32'h0000_2000, 1'b1, 32'h6000_2715, 32'h0000_5554, 16'h2715, 32'h0000_200A, "R7");
        drain();

        // Requests while busy are ignored (R10)
        lat = 2;
        do_entry(8'd7, 1'b0, 3'd0, 32'h0000_6000, 16'h0004, 32'h0000_C000, 32'h0, 32'h4444_0000, "R10");
        exc_idx = 8'd8; cur_pc = 32'h0000_7777; cur_sp = 32'h0000_D000; enter_req = 1'b1; ret_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0; ret_req = 1'b0;
        drain();

        // Round trip from an odd stack pointer (R7 R3)
        lat = 0;
        do_entry(8'd33, 1'b0, 3'd0, 32'h0000_8000, 16'h0013, 32'h0000_3001, 32'h0, 32'h5555_0000, "R7");
        drain();
        do_ret(32'h0000_2FF8, 1'b0, 32'h0, 32'h0000_8002, 16'h0013, 32'h0000_3001, "R7");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule